// File: doc/BRIEF.md
# Trap Level Stack Controller

This block tracks how deeply a 64-bit processor is nested in traps. It holds the current trap level and an eight-entry save array. Each entry holds a saved program counter, a saved next program counter and a packed 40-bit state word. When a trap is accepted, the level rises by one. The interrupted context is then packed and written into the entry that the new level selects. When a done or retry return arrives, the entry at the current level is unpacked into a restored processor-state value and a restored window pointer, and the level falls by one.

The nesting limit comes from a configuration input, so one netlist serves cores with limits of 4, 5, 6 or up to 8 levels. A trap that brings the level up to the limit turns on the reduced-error flag. A trap that arrives once the level is already at or past the limit does not change the level. Instead it latches a fatal error state. A read-only version word reports the limit and the register-window count.

Top module: `trap_level_stack`

## Requirements
- R1: After reset the level is 0, and the reduced-error flag, the error flag, the illegal-return pulse and the restore-valid pulse are all 0.
- R2: An accepted trap at a level below limit-1 raises the level by one and leaves the reduced-error flag unchanged. The new level shows one cycle after the request.
- R3: An accepted trap at level limit-1 raises the level to the limit and sets the reduced-error flag, which stays set until reset.
- R4: A trap at a level at or above the limit leaves the level unchanged and sets the error flag, which stays set until reset. While that flag is set, both traps and returns are ignored.
- R5: An accepted trap writes the state word into the entry selected by the new level. The word packs condition codes in [39:32], the ASI in [31:24], the processor state (bit 5 forced on when the reduced-error flag is on after this trap) ANDed with 0xF3F in [19:8], zeros in [23:20] and the window pointer in [7:0]. The saved PC and next PC are written in the same cycle. All three outputs show the entry at the current level.
- R6: A return at a nonzero level produces, one cycle later, a one-cycle restore-valid pulse. With it come the restored processor state (bits [19:8] of the current entry ANDed with 0xF3F) and the restored window pointer (bits [7:0]), and the level drops by one.
- R7: A return at level 0 leaves the level unchanged, gives no restore-valid pulse, and raises the illegal-return flag for exactly one cycle.
- R8: When a trap and a return are requested in the same cycle, only the trap takes effect.
- R9: The save array is always indexed by the level ANDed with 7, so level 8 uses entry 0.
- R10: The version word carries the limit in bits [15:8] and the window count minus one in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_level | input | TLW | Trap nesting limit |
| trap_req | input | 1 | Trap request |
| ret_req | input | 1 | Done/retry return request |
| ccr_in | input | 8 | Condition codes of the interrupted context |
| asi_in | input | 8 | Current ASI |
| pstate_in | input | 12 | Current processor state |
| cwp_in | input | 8 | Current window pointer |
| pc_in | input | PCW | PC to save |
| npc_in | input | PCW | Next PC to save |
| level | output | TLW | Current trap level |
| red_mode | output | 1 | Reduced-error flag |
| err_state | output | 1 | Fatal error state |
| ill_ret | output | 1 | Illegal return pulse |
| saved_pc | output | PCW | Saved PC at the current level |
| saved_npc | output | PCW | Saved next PC at the current level |
| saved_state | output | 40 | Packed state word at the current level |
| ret_vld | output | 1 | Restore outputs valid pulse |
| rest_pstate | output | 12 | Restored processor state |
| rest_cwp | output | 8 | Restored window pointer |
| version | output | 16 | Version word |

## Verification
A wrong level counter shows up on the level output one cycle after the trap or return that corrupted it. It also shows up at once on the saved outputs, because they follow the level. A slip in how entries are indexed or packed stays hidden until the block walks back down to the damaged entry. It then appears in the restore outputs in the cycle after that return. The bench therefore climbs all the way to the limit and unwinds fully, and it repeats this with a limit of 8 so that the masked index wraps.

// File: rtl/trap_level_stack.sv
module trap_level_stack #(
  parameter int PCW  = 64,
  parameter int TLW  = 4,
  parameter int NWIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TLW-1:0] max_level,
  input  logic           trap_req,
  input  logic           ret_req,
  input  logic [7:0]     ccr_in,
  input  logic [7:0]     asi_in,
  input  logic [11:0]    pstate_in,
  input  logic [7:0]     cwp_in,
  input  logic [PCW-1:0] pc_in,
  input  logic [PCW-1:0] npc_in,
  output logic [TLW-1:0] level,
  output logic           red_mode,
  output logic           err_state,
  output logic           ill_ret,
  output logic [PCW-1:0] saved_pc,
  output logic [PCW-1:0] saved_npc,
  output logic [39:0]    saved_state,
  output logic           ret_vld,
  output logic [11:0]    rest_pstate,
  output logic [7:0]     rest_cwp,
  output logic [15:0]    version
);
  localparam int DEPTH   = 8;
  localparam int IDXW    = $clog2(DEPTH);
  localparam int RED_BIT = 5;
  localparam logic [11:0] PS_MASK = 12'hF3F;

  logic [PCW-1:0] pc_mem  [DEPTH];
  logic [PCW-1:0] npc_mem [DEPTH];
  logic [39:0]    st_mem  [DEPTH];

  logic [TLW-1:0] tl_q;
  logic           red_q, err_q;

  wire [TLW-1:0]  tl_inc  = tl_q + TLW'(1);
  wire [IDXW-1:0] rd_idx  = tl_q[IDXW-1:0];
  wire [IDXW-1:0] wr_idx  = tl_inc[IDXW-1:0];
  wire            trap_ok = trap_req & ~err_q & (tl_q < max_level);
  wire            trap_bad = trap_req & ~err_q & (tl_q >= max_level);
  wire            ret_act = ret_req & ~trap_req & ~err_q;
  wire            ret_ok  = ret_act & (tl_q != '0);
  wire            red_now = trap_ok & (tl_inc == max_level);
  wire            red_nxt = red_q | red_now;
  wire [11:0]     ps_save = (pstate_in | (12'(red_nxt) << RED_BIT)) & PS_MASK;
  wire [39:0]     word_in = {ccr_in, asi_in, 4'b0, ps_save, cwp_in};
  wire [39:0]     cur_word = st_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (trap_ok) begin
      pc_mem[wr_idx]  <= pc_in;
      npc_mem[wr_idx] <= npc_in;
      st_mem[wr_idx]  <= word_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_q        <= '0;
      red_q       <= 1'b0;
      err_q       <= 1'b0;
      ill_ret     <= 1'b0;
      ret_vld     <= 1'b0;
      rest_pstate <= '0;
      rest_cwp    <= '0;
    end else begin
      ill_ret <= ret_act & (tl_q == '0);
      ret_vld <= ret_ok;
      if (trap_bad) err_q <= 1'b1;
      if (red_now)  red_q <= 1'b1;
      if (trap_ok) begin
        tl_q <= tl_inc;
      end else if (ret_ok) begin
        tl_q        <= tl_q - TLW'(1);
        rest_pstate <= cur_word[19:8] & PS_MASK;
        rest_cwp    <= cur_word[7:0];
      end
    end
  end

  assign level       = tl_q;
  assign red_mode    = red_q;
  assign err_state   = err_q;
  assign saved_pc    = pc_mem[rd_idx];
  assign saved_npc   = npc_mem[rd_idx];
  assign saved_state = cur_word;
  assign version     = {8'(max_level), 8'(NWIN - 1)};
endmodule

module trap_level_stack_chk #(
  parameter int TLW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TLW-1:0] max_level,
  input logic           trap_req,
  input logic           ret_req,
  input logic [TLW-1:0] level,
  input logic           red_mode,
  input logic           err_state,
  input logic           ill_ret,
  input logic           ret_vld
);
  AST_TRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !err_state && level < max_level |=> level == $past(level) + TLW'(1)); // R2

  AST_RED_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !err_state && level + TLW'(1) == max_level && level < max_level |=> red_mode); // R3

  AST_RED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    red_mode |=> red_mode); // R3

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !err_state && level >= max_level |=> err_state && $stable(level)); // R4

  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |=> err_state && $stable(level) && !ret_vld); // R4

  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req && !trap_req && !err_state && level != '0 |=> ret_vld && level == $past(level) - TLW'(1)); // R6

  AST_RET_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req && !trap_req && !err_state && level == '0 |=> ill_ret && !ret_vld && level == '0); // R7

  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && ret_req |=> !ret_vld && !ill_ret); // R8
endmodule

bind trap_level_stack trap_level_stack_chk #(.TLW(TLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .max_level(max_level), .trap_req(trap_req),
  .ret_req(ret_req), .level(level), .red_mode(red_mode), .err_state(err_state),
  .ill_ret(ill_ret), .ret_vld(ret_vld)
);

// File: tb/trap_level_stack_bench.sv
module trap_level_stack_bench;
  localparam int PCW = 64;
  localparam int TLW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TLW-1:0] max_level = 4'd4;
  logic trap_req = 1'b0, ret_req = 1'b0;
  logic [7:0] ccr_in = '0, asi_in = '0, cwp_in = '0;
  logic [11:0] pstate_in = '0;
  logic [PCW-1:0] pc_in = '0, npc_in = '0;
  logic [TLW-1:0] level;
  logic red_mode, err_state, ill_ret, ret_vld;
  logic [PCW-1:0] saved_pc, saved_npc;
  logic [39:0] saved_state;
  logic [11:0] rest_pstate;
  logic [7:0] rest_cwp;
  logic [15:0] version;

  int checks = 0, errors = 0;
  int tl_m = 0;
  bit red_m = 0;
  logic [39:0]    w_m  [8];
  logic [PCW-1:0] pc_m [8];
  logic [PCW-1:0] npc_m[8];

  always #2.5 clk = ~clk;

  trap_level_stack u_trap_level_stack (
    .clk(clk), .rst_n(rst_n), .max_level(max_level), .trap_req(trap_req),
    .ret_req(ret_req), .ccr_in(ccr_in), .asi_in(asi_in), .pstate_in(pstate_in),
    .cwp_in(cwp_in), .pc_in(pc_in), .npc_in(npc_in), .level(level),
    .red_mode(red_mode), .err_state(err_state), .ill_ret(ill_ret),
    .saved_pc(saved_pc), .saved_npc(saved_npc), .saved_state(saved_state),
    .ret_vld(ret_vld), .rest_pstate(rest_pstate), .rest_cwp(rest_cwp),
    .version(version)
  );

  task automatic chk(input bit ok, input string req, input logic [PCW-1:0] act, input logic [PCW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [TLW-1:0] lim);
    max_level = lim;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tl_m = 0; red_m = 0;
    chk(level == 0, "R1 level", level, 0);
    chk({red_mode, err_state, ill_ret, ret_vld} == 4'b0, "R1 flags",
        {red_mode, err_state, ill_ret, ret_vld}, 0);
  endtask

  task automatic trap_step(input logic [7:0] cc, input logic [7:0] as, input logic [11:0] ps,
                           input logic [7:0] cw, input logic [PCW-1:0] pc, input bit with_ret);
    logic [11:0] psx;
    @(negedge clk);
    ccr_in = cc; asi_in = as; pstate_in = ps; cwp_in = cw;
    pc_in = pc; npc_in = pc + 4;
    trap_req = 1'b1; ret_req = with_ret;
    @(negedge clk);
    trap_req = 1'b0; ret_req = 1'b0;
    tl_m++;
    if (tl_m == int'(max_level)) red_m = 1;
    psx = (ps | (red_m ? 12'h020 : 12'h000)) & 12'hF3F;
    w_m[tl_m & 7]   = {cc, as, 4'b0, psx, cw};
    pc_m[tl_m & 7]  = pc;
    npc_m[tl_m & 7] = pc + 4;
    chk(level == TLW'(tl_m), "R2 level after trap", level, tl_m);
    chk(red_mode == red_m, "R3 reduced-error flag", red_mode, red_m);
    chk(saved_state == w_m[tl_m & 7], "R5 state word", saved_state, w_m[tl_m & 7]);
    chk(saved_pc == pc_m[tl_m & 7] && saved_npc == npc_m[tl_m & 7], "R5 saved pc", saved_pc, pc_m[tl_m & 7]);
    if (with_ret) chk(!ret_vld, "R8 trap wins over return", ret_vld, 0);
  endtask

  task automatic ret_step;
    logic [39:0] w;
    w = w_m[tl_m & 7];
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    tl_m--;
    chk(ret_vld, "R6 restore valid", ret_vld, 1);
    chk(rest_pstate == (w[19:8] & 12'hF3F), "R6 restored pstate", rest_pstate, w[19:8] & 12'hF3F);
    chk(rest_cwp == w[7:0], "R6 restored cwp", rest_cwp, w[7:0]);
    chk(level == TLW'(tl_m), "R6 level after return", level, tl_m);
    @(negedge clk);
    chk(!ret_vld, "R6 restore pulse one cycle", ret_vld, 0);
  endtask

  task automatic ret_at_zero;
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    chk(ill_ret && !ret_vld, "R7 illegal return pulse", {ill_ret, ret_vld}, 2'b10);
    chk(level == 0, "R7 level stays 0", level, 0);
    @(negedge clk);
    chk(!ill_ret, "R7 pulse lasts one cycle", ill_ret, 0);
  endtask

  task automatic scenario_limit4;
    do_reset(4'd4);
    chk(version == 16'h0407, "R10 version", version, 16'h0407);
    trap_step(8'h11, 8'h80, 12'hFFF, 8'h03, 64'h1000, 0);
    trap_step(8'h22, 8'h81, 12'h0C0, 8'h04, 64'h2000, 0);
    chk(!red_mode, "R2 no red below limit", red_mode, 0);
    trap_step(8'h33, 8'h82, 12'h001, 8'h05, 64'h3000, 0);
    trap_step(8'h44, 8'h83, 12'h100, 8'h06, 64'h4000, 0);
    chk(saved_state[13] == 1'b1, "R5 red bit saved", saved_state[13], 1);
    ret_step();
    ret_step();
    trap_step(8'h55, 8'h1F, 12'hA5A, 8'h07, 64'h5000, 1);
    ret_step(); ret_step(); ret_step();
    ret_at_zero();
  endtask

  task automatic scenario_error;
    do_reset(4'd5);
    chk(version == 16'h0507, "R10 version limit 5", version, 16'h0507);
    for (int i = 0; i < 5; i++) trap_step(8'(i), 8'(i + 8), 12'(i * 3), 8'(i), 64'(i * 256), 0);
    @(negedge clk); trap_req = 1'b1; pc_in = 64'hDEAD;
    @(negedge clk); trap_req = 1'b0;
    chk(err_state, "R4 error set", err_state, 1);
    chk(level == 5, "R4 level unchanged", level, 5);
    chk(saved_pc == pc_m[5], "R4 entry untouched", saved_pc, pc_m[5]);
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    chk(level == 5 && !ret_vld, "R4 return ignored in error", level, 5);
    @(negedge clk); trap_req = 1'b1;
    @(negedge clk); trap_req = 1'b0;
    chk(level == 5 && err_state, "R4 trap ignored in error", level, 5);
  endtask

  task automatic scenario_wrap;
    do_reset(4'd8);
    for (int i = 0; i < 8; i++) trap_step(8'(i + 1), 8'(16 * i), 12'(i * 17), 8'(i + 2), 64'(i * 16 + 64'hA0000), 0);
    chk(level == 8, "R9 level reaches 8", level, 8);
    chk(saved_pc == 64'hA0070, "R9 level 8 maps to entry 0", saved_pc, 64'hA0070);
    ret_step();
    chk(saved_pc == 64'hA0060, "R9 level 7 entry", saved_pc, 64'hA0060);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    scenario_limit4();
    scenario_error();
    scenario_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule